// File: doc/BRIEF.md
# Strap-Level Probe Decoder

This block finds out at power-up how each of four configuration selector inputs is wired on the board. A selector can be tied low, tied high, or wired back to one of two of the chip's own output pins, which act as probes during start-up. The block drives three probe patterns in turn, holds each for a settle time, and samples the selectors through a two-flop synchroniser at the end of every pattern. The response of each selector across the three patterns gives it one of four strap codes.

Two selectors (0 and 1) then choose one of six carrier-frequency settings. The other two (2 and 3) choose one of thirteen modem settings. The block also reports whether the chosen modem setting is frequency-shift keyed and whether it enables squelch. When the sequence ends, the probes are released and the results hold until the next reset. A selector response that fits no code, or a selector pair with no entry, raises an invalid flag and forces both indices to zero.

The settle parameter must be at least 4 cycles, so that each sample sees the synchronised response to the current pattern.

Top module: `strap_probe_decoder`

## Requirements
- R1: While reset is low and right after it, `done_o` is 0, `probe_drive_o` is 1, both probes are 0, and all result outputs are 0. The sequence starts by itself when reset is released.
- R2: The probes step through three phases, each held for exactly SETTLE_CYCLES cycles. The pair (probe_out0_o, probe_out1_o) is (0,0) in phase 1, (1,0) in phase 2 and (0,1) in phase 3. `done_o` rises on the cycle after phase 3 ends, and the two probes are never high together.
- R3: Each selector's 2-bit code sits at `strap_code_o[2i+1:2i]`. The code is 0 for a selector low in all phases, 1 for high in all phases, 2 for high only in phase 3 (wired to probe 1), and 3 for high only in phase 2 (wired to probe 0).
- R4: Any other three-phase response sets that selector's code to 0 and raises `strap_err_o` and `invalid_o`.
- R5: The frequency index takes the code pairs (sel0,sel1) as follows: (0,1)→0, (1,1)→1, (2,1)→2, (0,2)→3, (1,2)→4, (2,2)→5.
- R6: The modem index takes the code pairs (sel2,sel3) as follows. With sel3=0, sel2 codes 0..3 give 0..3. With sel3=1, sel2 codes 0..1 give 4..5. With sel3=2, sel2 codes 0..3 give 6..9. With sel3=3, sel2 codes 0..2 give 10..12.
- R7: A frequency pair or modem pair outside those lists raises `invalid_o`. When `invalid_o` is high, `freq_idx_o`, `modem_idx_o`, `fsk_mode_o` and `squelch_o` are all 0.
- R8: On a valid result, `fsk_mode_o` is 1 for modem indices 6..12, and `squelch_o` is 1 only for indices 11 and 12.
- R9: Once `done_o` is high, it stays high until reset. The probes are released (`probe_drive_o` 0, both probes 0), and later changes on the selectors leave every result output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the probe sequence |
| sel_i | input | 4 | Selector inputs, asynchronous to clk |
| probe_out0_o | output | 1 | Probe 0 level |
| probe_out1_o | output | 1 | Probe 1 level |
| probe_drive_o | output | 1 | High while the probe pins carry probe patterns |
| strap_code_o | output | 8 | Strap code per selector, 2 bits each |
| strap_err_o | output | 1 | Some selector gave an unclassifiable response |
| freq_idx_o | output | 3 | Carrier-frequency index |
| modem_idx_o | output | 4 | Modem-configuration index |
| fsk_mode_o | output | 1 | Chosen modem setting is frequency-shift keyed |
| squelch_o | output | 1 | Chosen modem setting enables squelch |
| invalid_o | output | 1 | Result is unusable |
| done_o | output | 1 | Decoding complete |

## Verification
The bench sweeps all 256 ways of wiring the four selectors to ground, supply or either probe. That one sweep separates every strap code, every legal and illegal frequency pair, and every legal and illegal modem pair. Extra wirings respond to both probes or to the inverse of probe 1. These give responses that fit no code, and they show that an error on a single selector is flagged and zeroes its code. One walk through the sequence checks the probe levels cycle by cycle against the phase lengths. A further run changes the wiring after completion, to show that the results are frozen.

// File: rtl/strap_probe_pkg.sv
package strap_probe_pkg;

  localparam int SEL_COUNT        = 4;
  localparam int PHASES           = 3;
  localparam int FREQ_W           = 3;
  localparam int MODEM_W          = 4;
  localparam int MODEM_FSK_FIRST  = 6;
  localparam int MODEM_SQL_FIRST  = 11;
  localparam int MODEM_LAST       = 12;

  typedef enum logic [1:0] {
    STRAP_GND  = 2'd0,
    STRAP_VDD  = 2'd1,
    STRAP_OUT1 = 2'd2,
    STRAP_OUT0 = 2'd3
  } strap_t;

  typedef enum logic [1:0] {
    SEQ_LOWLOW = 2'd0,
    SEQ_P0HIGH = 2'd1,
    SEQ_P1HIGH = 2'd2,
    SEQ_DONE   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic   bad;
    strap_t code;
  } strap_class_t;

  typedef struct packed {
    logic              ok;
    logic [FREQ_W-1:0] idx;
  } freq_sel_t;

  typedef struct packed {
    logic               ok;
    logic [MODEM_W-1:0] idx;
  } modem_sel_t;

  // bit0: response in phase 1, bit1: phase 2, bit2: phase 3
  function automatic strap_class_t classify(input logic [PHASES-1:0] seen);
    strap_class_t r;
    r.bad  = 1'b0;
    r.code = STRAP_GND;
    case (seen)
      3'b000:  r.code = STRAP_GND;
      3'b111:  r.code = STRAP_VDD;
      3'b010:  r.code = STRAP_OUT0;
      3'b100:  r.code = STRAP_OUT1;
      default: r.bad  = 1'b1;
    endcase
    return r;
  endfunction

  function automatic freq_sel_t freq_decode(input strap_t s0, input strap_t s1);
    freq_sel_t r;
    r.ok  = ((s1 == STRAP_VDD) || (s1 == STRAP_OUT1)) && (s0 != STRAP_OUT0);
    r.idx = '0;
    if (r.ok)
      r.idx = {1'b0, s0} + ((s1 == STRAP_OUT1) ? FREQ_W'(3) : FREQ_W'(0));
    return r;
  endfunction

  function automatic modem_sel_t modem_decode(input strap_t s2, input strap_t s3);
    modem_sel_t         r;
    logic [MODEM_W-1:0] base;
    case (s3)
      STRAP_GND:  begin r.ok = 1'b1;                base = MODEM_W'(0);  end
      STRAP_VDD:  begin r.ok = (s2 == STRAP_GND) ||
                               (s2 == STRAP_VDD);   base = MODEM_W'(4);  end
      STRAP_OUT1: begin r.ok = 1'b1;                base = MODEM_W'(6);  end
      default:    begin r.ok = (s2 != STRAP_OUT0);  base = MODEM_W'(10); end
    endcase
    r.idx = r.ok ? (base + {2'b00, s2}) : '0;
    return r;
  endfunction

  function automatic logic modem_is_fsk(input logic [MODEM_W-1:0] idx);
    return idx >= MODEM_W'(MODEM_FSK_FIRST);
  endfunction

  function automatic logic modem_has_squelch(input logic [MODEM_W-1:0] idx);
    return (idx >= MODEM_W'(MODEM_SQL_FIRST)) && (idx <= MODEM_W'(MODEM_LAST));
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[g];
        stable_q <= meta_q;
      end
    end
    assign sync_o[g] = stable_q;
  end

endmodule

// File: rtl/strap_sequencer.sv
module strap_sequencer
  import strap_probe_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       probe0_o,
  output logic       probe1_o,
  output logic       drive_o,
  output logic       samp_stb_o,
  output logic [1:0] samp_phase_o,
  output logic       done_o
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_end;

  assign phase_end = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_LOWLOW;
      cnt_q   <= '0;
    end else if (state_q != SEQ_DONE) begin
      if (phase_end) begin
        cnt_q <= '0;
        case (state_q)
          SEQ_LOWLOW: state_q <= SEQ_P0HIGH;
          SEQ_P0HIGH: state_q <= SEQ_P1HIGH;
          default:    state_q <= SEQ_DONE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign probe0_o     = (state_q == SEQ_P0HIGH);
  assign probe1_o     = (state_q == SEQ_P1HIGH);
  assign drive_o      = (state_q != SEQ_DONE);
  assign samp_stb_o   = drive_o && phase_end;
  assign samp_phase_o = state_q;
  assign done_o       = (state_q == SEQ_DONE);

endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_probe_pkg::*;
#(
  parameter int NSEL = SEL_COUNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSEL-1:0]      sel_sync_i,
  input  logic                 samp_stb_i,
  input  logic [1:0]           samp_phase_i,
  output logic [NSEL-1:0][1:0] code_o,
  output logic [NSEL-1:0]      bad_o
);

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic [PHASES-1:0] seen_q;
    strap_class_t      cls;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q <= '0;
      end else if (samp_stb_i && (samp_phase_i != 2'd3)) begin
        seen_q[samp_phase_i] <= sel_sync_i[g];
      end
    end

    assign cls       = classify(seen_q);
    assign code_o[g] = cls.bad ? 2'b00 : cls.code;
    assign bad_o[g]  = cls.bad;
  end

endmodule

// File: rtl/strap_probe_decoder.sv
module strap_probe_decoder
  import strap_probe_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_COUNT-1:0]   sel_i,
  output logic                   probe_out0_o,
  output logic                   probe_out1_o,
  output logic                   probe_drive_o,
  output logic [2*SEL_COUNT-1:0] strap_code_o,
  output logic                   strap_err_o,
  output logic [FREQ_W-1:0]      freq_idx_o,
  output logic [MODEM_W-1:0]     modem_idx_o,
  output logic                   fsk_mode_o,
  output logic                   squelch_o,
  output logic                   invalid_o,
  output logic                   done_o
);

  logic [SEL_COUNT-1:0]      sel_sync;
  logic                      samp_stb;
  logic [1:0]                samp_phase;
  logic                      seq_done;
  logic [SEL_COUNT-1:0][1:0] codes;
  logic [SEL_COUNT-1:0]      bad;
  logic                      any_bad;
  freq_sel_t                 fsel;
  modem_sel_t                msel;
  logic                      result_bad;
  logic                      result_ok;

  strap_sync #(.WIDTH(SEL_COUNT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sel_i),
    .sync_o  (sel_sync)
  );

  strap_sequencer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .probe0_o     (probe_out0_o),
    .probe1_o     (probe_out1_o),
    .drive_o      (probe_drive_o),
    .samp_stb_o   (samp_stb),
    .samp_phase_o (samp_phase),
    .done_o       (seq_done)
  );

  strap_classifier #(.NSEL(SEL_COUNT)) u_cls (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_sync_i   (sel_sync),
    .samp_stb_i   (samp_stb),
    .samp_phase_i (samp_phase),
    .code_o       (codes),
    .bad_o        (bad)
  );

  assign any_bad    = |bad;
  assign fsel       = freq_decode(strap_t'(codes[0]), strap_t'(codes[1]));
  assign msel       = modem_decode(strap_t'(codes[2]), strap_t'(codes[3]));
  assign result_bad = any_bad || !fsel.ok || !msel.ok;
  assign result_ok  = seq_done && !result_bad;

  assign done_o       = seq_done;
  assign strap_code_o = seq_done ? codes : '0;
  assign strap_err_o  = seq_done && any_bad;
  assign invalid_o    = seq_done && result_bad;
  assign freq_idx_o   = result_ok ? fsel.idx : '0;
  assign modem_idx_o  = result_ok ? msel.idx : '0;
  assign fsk_mode_o   = result_ok && modem_is_fsk(msel.idx);
  assign squelch_o    = result_ok && modem_has_squelch(msel.idx);

endmodule

// File: rtl/strap_probe_decoder_chk.sv
module strap_probe_decoder_chk
  import strap_probe_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   probe_out0_o,
  input logic                   probe_out1_o,
  input logic                   probe_drive_o,
  input logic [2*SEL_COUNT-1:0] strap_code_o,
  input logic                   strap_err_o,
  input logic [FREQ_W-1:0]      freq_idx_o,
  input logic [MODEM_W-1:0]     modem_idx_o,
  input logic                   fsk_mode_o,
  input logic                   squelch_o,
  input logic                   invalid_o,
  input logic                   done_o,
  input logic                   samp_stb
);

  // R2
  probe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_out0_o && probe_out1_o));

  // R2
  stb_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> probe_drive_o);

  // R1
  quiet_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (strap_code_o == '0) && !invalid_o && !strap_err_o &&
                (freq_idx_o == '0) && (modem_idx_o == '0));

  // R4
  err_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_err_o |-> invalid_o);

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (freq_idx_o == '0) && (modem_idx_o == '0) && !fsk_mode_o && !squelch_o);

  // R8
  squelch_fsk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squelch_o |-> fsk_mode_o);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R9
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !probe_drive_o && !probe_out0_o && !probe_out1_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(strap_code_o) && $stable(freq_idx_o) &&
               $stable(modem_idx_o) && $stable(invalid_o));

endmodule

bind strap_probe_decoder strap_probe_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .probe_out0_o  (probe_out0_o),
  .probe_out1_o  (probe_out1_o),
  .probe_drive_o (probe_drive_o),
  .strap_code_o  (strap_code_o),
  .strap_err_o   (strap_err_o),
  .freq_idx_o    (freq_idx_o),
  .modem_idx_o   (modem_idx_o),
  .fsk_mode_o    (fsk_mode_o),
  .squelch_o     (squelch_o),
  .invalid_o     (invalid_o),
  .done_o        (done_o),
  .samp_stb      (samp_stb)
);

// File: tb/strap_probe_decoder_test.sv
`timescale 1ns/1ps
module strap_probe_decoder_test;

  localparam int SETTLE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel;
  logic       p0, p1, pdrv, serr, fsk, sql, inv, done;
  logic [7:0] codes;
  logic [2:0] fidx;
  logic [3:0] midx;

  // wiring per selector: 0 ground, 1 supply, 2 probe 1, 3 probe 0,
  // 4 both probes OR-ed, 5 inverse of probe 1
  int src [4];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      case (src[i])
        0: sel[i] = 1'b0;
        1: sel[i] = 1'b1;
        2: sel[i] = p1;
        3: sel[i] = p0;
        4: sel[i] = p0 | p1;
        default: sel[i] = ~p1;
      endcase
    end
  end

  strap_probe_decoder #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel),
    .probe_out0_o(p0), .probe_out1_o(p1), .probe_drive_o(pdrv),
    .strap_code_o(codes), .strap_err_o(serr), .freq_idx_o(fidx),
    .modem_idx_o(midx), .fsk_mode_o(fsk), .squelch_o(sql),
    .invalid_o(inv), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_freq(input int a, input int b);
    if (a == 0 && b == 1) return 0;
    if (a == 1 && b == 1) return 1;
    if (a == 2 && b == 1) return 2;
    if (a == 0 && b == 2) return 3;
    if (a == 1 && b == 2) return 4;
    if (a == 2 && b == 2) return 5;
    return -1;
  endfunction

  function automatic int exp_modem(input int s2, input int s3);
    int order [13][2] = '{'{0,0},'{1,0},'{2,0},'{3,0},'{0,1},'{1,1},
                          '{0,2},'{1,2},'{2,2},'{3,2},'{0,3},'{1,3},'{2,3}};
    for (int k = 0; k < 13; k++)
      if (order[k][0] == s2 && order[k][1] == s3) return k;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input int a, input int b, input int c, input int d);
    int  s [4];
    int  f, m;
    bit  anybad, ok;
    s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    for (int i = 0; i < 4; i++) src[i] = s[i];
    do_reset();
    repeat (3*SETTLE) @(negedge clk);
    #1;
    check("R2 done after three phases", int'(done), 1);
    anybad = 0;
    for (int i = 0; i < 4; i++) begin
      if (s[i] > 3) anybad = 1;
      if (s[i] > 3) check("R4 bad pin code", int'(codes[2*i +: 2]), 0);
      else          check("R3 strap code", int'(codes[2*i +: 2]), s[i]);
    end
    check("R4 strap_err", int'(serr), int'(anybad));
    f = anybad ? -1 : exp_freq(s[0], s[1]);
    m = anybad ? -1 : exp_modem(s[2], s[3]);
    ok = (f >= 0) && (m >= 0);
    check("R7 invalid", int'(inv), int'(!ok));
    check("R5 freq_idx", int'(fidx), ok ? f : 0);
    check("R6 modem_idx", int'(midx), ok ? m : 0);
    check("R8 fsk_mode", int'(fsk), int'(ok && m >= 6));
    check("R8 squelch", int'(sql), int'(ok && (m == 11 || m == 12)));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) src[i] = 0;
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    check("R1 done in reset", int'(done), 0);
    check("R1 drive in reset", int'(pdrv), 1);
    check("R1 probes in reset", int'({p0, p1}), 0);
    check("R1 codes in reset", int'(codes), 0);
    check("R1 invalid in reset", int'(inv), 0);

    // R2: cycle-by-cycle probe walk
    src[0] = 2; src[1] = 1; src[2] = 3; src[3] = 0;
    do_reset();
    for (int k = 0; k < 3*SETTLE; k++) begin
      #1;
      check("R2 probe0 level", int'(p0), int'(k / SETTLE == 1));
      check("R2 probe1 level", int'(p1), int'(k / SETTLE == 2));
      check("R2 drive during probing", int'(pdrv), 1);
      check("R2 not done yet", int'(done), 0);
      @(negedge clk);
    end
    #1;
    check("R2 done rises", int'(done), 1);
    check("R9 probes released", int'({pdrv, p0, p1}), 0);

    // exhaustive legal-wiring sweep: R3 R5 R6 R7 R8
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            run_cfg(a, b, c, d);

    // R4: unclassifiable responses
    run_cfg(4, 1, 0, 0);
    run_cfg(0, 5, 0, 0);
    run_cfg(1, 1, 4, 2);
    run_cfg(2, 2, 0, 5);
    run_cfg(4, 5, 4, 5);

    // R9: results frozen after done even if wiring changes
    run_cfg(1, 2, 1, 3);
    src[0] = 0; src[1] = 0; src[2] = 3; src[3] = 3;
    repeat (12) @(negedge clk);
    #1;
    check("R9 done sticky", int'(done), 1);
    check("R9 probes stay released", int'({pdrv, p0, p1}), 0);
    check("R9 codes held", int'(codes), (3 << 6) | (1 << 4) | (2 << 2) | 1);
    check("R9 freq held", int'(fidx), 4);
    check("R9 modem held", int'(midx), 11);
    check("R9 invalid held", int'(inv), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule